// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupt Detection

This block is a single bank of general-purpose I/O lines, up to 32 of them, controlled through a small 32-bit register bus. Every line can be an input or an output. An output can drive both levels or work as an open-drain driver that only pulls low. Every pin passes through a two-flop synchroniser, and the synchronised value is always available for readback.

Each line also has its own interrupt detector. Three per-line configuration bits choose the trigger: active-high or active-low level, rising edge, falling edge, or both edges. Detected events set sticky bits in an event register, and software clears those bits by writing ones to them. A per-line enable register gates the sticky bits onto one interrupt output for the whole bank. A line is configured by writing its direction, drive and trigger bits. Software then clears stale events, sets the enable bit, and services the interrupt by reading the event register and writing back the bits it has handled.

Top module: `pio_bank`

## Requirements
- R1: After reset, every register reads zero. `pad_oe` is all ones and `pad_o` is all zeros, so every line drives low. `irq` is 0.
- R2: The bus address is a word index with this fixed map: 0 open-drain, 1 pin/output value, 2 direction, 3 polarity, 4 both-edges, 5 interrupt enable, 6 level-mode, 7 event status. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` updates at the clock edge where `bus_rd` is high and holds its value otherwise. Bits at or above WIDTH are discarded on write and read as zero.
- R3: A direction bit of 1 makes the line an input, with its `pad_oe` bit at 0. A direction bit of 0 makes it an output. Reading word 1 returns the synchronised pin for input lines and the stored output value for output lines.
- R4: For an output line with its open-drain bit at 1, an output value of 0 drives low and an output value of 1 releases the pad (`pad_oe` = 0). With the open-drain bit at 0, the line drives the output value.
- R5: With level-mode = 1, polarity 1 selects active-high and polarity 0 selects active-low. The status bit is set again on every cycle while the level stays active, so a clear has no lasting effect until the input goes inactive.
- R6: With level-mode = 0 and both-edges = 0, polarity 1 detects rising edges only and polarity 0 detects falling edges only.
- R7: With level-mode = 0 and both-edges = 1, both edges are detected and the polarity bit is ignored.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: `irq` is 1 exactly when some line has both its status bit and its enable bit set.
- R10: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: A pin change made between clock edges sets the status bit on the third rising edge after it: two edges of synchroniser and one of status register. `irq` is still 0 after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Registered read data |
| pad_i | input | WIDTH | Pin input values |
| pad_o | output | WIDTH | Pin drive values |
| pad_oe | output | WIDTH | Pin output enables |
| irq | output | 1 | Bank interrupt |

## Verification
The bench aims at the places where the edge and level paths can be confused:
- A falling edge seen in rising mode, or a rising edge seen in falling mode, would show up as a spurious status bit.
- In both-edges mode, a polarity bit that leaks through would lose one of the two edges.
- A clear that lands in the same cycle as an event is timed on purpose. A design that gives the clear priority would lose that event.
- A level line is cleared while still active. A design that treats level as a one-shot would read back zero.
- The interrupt is sampled one edge early. A design with a missing or extra synchroniser stage would assert `irq` too early or too late.
- Random register traffic checks the open-drain release, the direction-dependent readback of word 1, and the zeroing of bits above the bank width.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;

  localparam int unsigned REG_COUNT = 8;
  localparam int unsigned AW = $clog2(REG_COUNT);

  typedef enum logic [AW-1:0] {
    REG_OD   = 3'd0,
    REG_VAL  = 3'd1,
    REG_DIR  = 3'd2,
    REG_POL  = 3'd3,
    REG_BOTH = 3'd4,
    REG_EN   = 3'd5,
    REG_LVL  = 3'd6,
    REG_EVT  = 3'd7
  } reg_sel_e;

  // Trigger decode for one line: level mode wins, then both-edges, then polarity.
  function automatic logic line_event(input logic lvl, input logic pol,
                                      input logic both, input logic cur,
                                      input logic prev);
    if (lvl)  return pol ? cur : ~cur;
    if (both) return cur ^ prev;
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Pad enable for one line.
  function automatic logic pad_enable(input logic dir, input logic od,
                                      input logic val);
    return ~dir & (~od | ~val);
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else if (g == 0) stage[g] <= pin;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else prev <= stage[STAGES-1];
  end

  assign cur = stage[STAGES-1];

endmodule

// File: rtl/pio_detect.sv
module pio_detect
  import pio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] pol,
  input  logic [WIDTH-1:0] both,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  output logic [WIDTH-1:0] ev
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_line
      assign ev[g] = line_event(lvl[g], pol[g], both[g], cur[g], prev[g]);
    end
  endgenerate

endmodule

// File: rtl/pio_pad.sv
module pio_pad
  import pio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] od,
  input  logic [WIDTH-1:0] val,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_line
      assign pad_oe[g] = pad_enable(dir[g], od[g], val[g]);
      assign pad_o[g]  = val[g] & ~od[g];
    end
  endgenerate

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  input  logic [WIDTH-1:0] pin_cur,
  input  logic [WIDTH-1:0] line_ev,
  output logic [WIDTH-1:0] od_q,
  output logic [WIDTH-1:0] val_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pol_q,
  output logic [WIDTH-1:0] both_q,
  output logic [WIDTH-1:0] en_q,
  output logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] stat_q
);

  function automatic logic [DW-1:0] widen(input logic [WIDTH-1:0] x);
    logic [DW-1:0] r;
    r = '0;
    r[WIDTH-1:0] = x;
    return r;
  endfunction

  reg_sel_e         sel;
  logic [WIDTH-1:0] wbits;
  logic [WIDTH-1:0] clr;
  logic [WIDTH-1:0] stat_next;
  logic [WIDTH-1:0] pin_view;
  logic [DW-1:0]    rd_mux;

  assign sel       = reg_sel_e'(addr);
  assign wbits     = wr_data[WIDTH-1:0];
  assign clr       = (wr_en && sel == REG_EVT) ? wbits : '0;
  assign stat_next = (stat_q & ~clr) | line_ev;
  assign pin_view  = (val_q & ~dir_q) | (pin_cur & dir_q);

  always_comb begin
    case (sel)
      REG_OD:   rd_mux = widen(od_q);
      REG_VAL:  rd_mux = widen(pin_view);
      REG_DIR:  rd_mux = widen(dir_q);
      REG_POL:  rd_mux = widen(pol_q);
      REG_BOTH: rd_mux = widen(both_q);
      REG_EN:   rd_mux = widen(en_q);
      REG_LVL:  rd_mux = widen(lvl_q);
      default:  rd_mux = widen(stat_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q    <= '0;
      val_q   <= '0;
      dir_q   <= '0;
      pol_q   <= '0;
      both_q  <= '0;
      en_q    <= '0;
      lvl_q   <= '0;
      stat_q  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        case (sel)
          REG_OD:   od_q   <= wbits;
          REG_VAL:  val_q  <= wbits;
          REG_DIR:  dir_q  <= wbits;
          REG_POL:  pol_q  <= wbits;
          REG_BOTH: both_q <= wbits;
          REG_EN:   en_q   <= wbits;
          REG_LVL:  lvl_q  <= wbits;
          default:  ;
        endcase
      end
      stat_q <= stat_next;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_rd,
  output logic [DW-1:0]    bus_rdata,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe,
  output logic             irq
);

  logic [WIDTH-1:0] pin_cur, pin_prev, line_ev;
  logic [WIDTH-1:0] od_q, val_q, dir_q, pol_q, both_q, en_q, lvl_q, stat_q;
  logic [WIDTH-1:0] active;

  pio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pad_i), .cur(pin_cur), .prev(pin_prev)
  );

  pio_detect #(.WIDTH(WIDTH)) u_detect (
    .lvl(lvl_q), .pol(pol_q), .both(both_q),
    .cur(pin_cur), .prev(pin_prev), .ev(line_ev)
  );

  pio_regs #(.WIDTH(WIDTH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
    .wr_data(bus_wdata), .rd_en(bus_rd), .rd_data(bus_rdata),
    .pin_cur(pin_cur), .line_ev(line_ev),
    .od_q(od_q), .val_q(val_q), .dir_q(dir_q), .pol_q(pol_q),
    .both_q(both_q), .en_q(en_q), .lvl_q(lvl_q), .stat_q(stat_q)
  );

  pio_pad #(.WIDTH(WIDTH)) u_pad (
    .dir(dir_q), .od(od_q), .val(val_q), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  assign active = stat_q & en_q;
  assign irq    = |active;

endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
  import pio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic [WIDTH-1:0] line_ev,
  input logic [WIDTH-1:0] stat_q,
  input logic [WIDTH-1:0] en_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] pad_oe,
  input logic             irq
);

  // R10 / R5: an event always leaves its status bit set, even against a clear
  a_r10_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & $past(line_ev)) == $past(line_ev)));

  // R8: a written one clears the bit unless an event hit it in that cycle
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_EVT) |=>
      ((stat_q & $past(bus_wdata[WIDTH-1:0]) & ~$past(line_ev)) == '0));

  // R8: status bits only rise where an event was seen
  a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(line_ev)) == '0));

  // R9: with no line enabled the interrupt is quiet
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R9: the interrupt never fires without a pending status bit
  a_r9_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));

  // R3: an input line never has its pad enabled
  a_r3_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & pad_oe) == '0));

endmodule

bind pio_bank pio_bank_chk #(.WIDTH(WIDTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .line_ev(line_ev), .stat_q(stat_q), .en_q(en_q),
  .dir_q(dir_q), .pad_oe(pad_oe), .irq(irq)
);

// File: tb/pio_bank_test.sv
module pio_bank_test;

  localparam int unsigned W  = 24;
  localparam int unsigned DW = 32;
  localparam logic [31:0] WM = (32'h1 << W) - 1;
  localparam int L = 5;
  localparam logic [31:0] LB = 32'h1 << L;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [W-1:0]  pad_i = '0;
  logic [W-1:0]  pad_o, pad_oe;
  logic          irq;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  pio_bank #(.WIDTH(W), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  // bench view of the pad drive
  function automatic logic [W-1:0] exp_oe(input logic [31:0] dir, od, val);
    return W'(~dir & (~od | ~val));
  endfunction
  function automatic logic [W-1:0] exp_high(input logic [31:0] dir, od, val);
    return W'(~dir & ~od & val);
  endfunction

  task automatic set_mode(input bit lvl, input bit pol, input bit both);
    wr(6, lvl ? LB : 0);
    wr(3, pol ? LB : 0);
    wr(4, both ? LB : 0);
  endtask

  task automatic settle_clear();
    repeat (4) @(negedge clk);
    wr(7, 32'hFFFF_FFFF);
  endtask

  task automatic move_pin(input bit v);
    @(negedge clk);
    pad_i[L] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  logic [31:0] v;
  logic [31:0] sh [7];

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R1 reset reg", v, 32'h0);
    end
    check("R1 reset pad_oe", 32'(pad_oe), WM);
    check("R1 reset pad_o", 32'(pad_o), 32'h0);
    check("R1 reset irq", 32'(irq), 32'h0);

    // R2 upper bits read zero
    wr(5, 32'hFFFF_FFFF);
    rd(5, v);
    check("R2 width clip", v, WM);
    wr(5, 0);

    // R2 R3 R4 random register traffic
    for (int a = 0; a < 7; a++) sh[a] = 0;
    for (int k = 0; k < 60; k++) begin
      int a, ra;
      logic [31:0] d, e;
      a = $urandom_range(0, 6);
      if (a == 5) a = 0;
      d = $urandom;
      wr(a, d);
      sh[a] = d & WM;
      pad_i = W'($urandom);
      repeat (3) @(negedge clk);
      ra = $urandom_range(0, 6);
      rd(ra, v);
      if (ra == 1) e = (sh[1] & ~sh[2]) | (32'(pad_i) & sh[2]);
      else e = sh[ra];
      check(ra == 1 ? "R3 pin readback" : "R2 register readback", v, e);
      check("R4 pad enable", 32'(pad_oe), 32'(exp_oe(sh[2], sh[0], sh[1])));
      check("R4 pad drive high", 32'(pad_o & pad_oe), 32'(exp_high(sh[2], sh[0], sh[1])));
    end

    // directed interrupt tests on line L
    pad_i = '0;
    wr(0, 0); wr(1, 0); wr(2, WM); wr(5, LB);
    set_mode(0, 1, 0);
    settle_clear();
    rd(7, v);
    check("R8 cleared start", v, 0);

    // R6 rising, R11 timing, R9 irq
    @(negedge clk);
    pad_i[L] = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 irq not yet after two edges", 32'(irq), 0);
    @(negedge clk);
    check("R11 irq on third edge", 32'(irq), 1);
    rd(7, v);
    check("R6 rising sets", v, LB);
    wr(7, 32'h0);
    rd(7, v);
    check("R8 zero write keeps", v, LB);
    wr(7, ~LB);
    rd(7, v);
    check("R8 other-bit write keeps", v, LB);

    // R9 mask gating
    wr(5, 0);
    @(negedge clk);
    check("R9 masked irq", 32'(irq), 0);
    wr(5, LB);
    @(negedge clk);
    check("R9 unmasked irq", 32'(irq), 1);
    wr(7, LB);
    rd(7, v);
    check("R8 one clears", v, 0);
    check("R9 irq after clear", 32'(irq), 0);
    move_pin(0);
    rd(7, v);
    check("R6 rising ignores fall", v, 0);

    // R6 falling
    set_mode(0, 0, 0);
    wr(7, 32'hFFFF_FFFF);
    move_pin(1);
    rd(7, v);
    check("R6 falling ignores rise", v, 0);
    move_pin(0);
    rd(7, v);
    check("R6 falling sets", v, LB);

    // R7 both edges, polarity set to each value
    for (int p = 0; p < 2; p++) begin
      set_mode(0, p[0], 1);
      wr(7, 32'hFFFF_FFFF);
      move_pin(1);
      rd(7, v);
      check("R7 both rise", v, LB);
      wr(7, LB);
      move_pin(0);
      rd(7, v);
      check("R7 both fall", v, LB);
      wr(7, LB);
    end

    // R5 level high and level low
    set_mode(1, 1, 0);
    move_pin(1);
    wr(7, LB);
    rd(7, v);
    check("R5 high level re-sets", v, LB);
    move_pin(0);
    wr(7, LB);
    rd(7, v);
    check("R5 high level inactive clears", v, 0);
    set_mode(1, 0, 0);
    repeat (2) @(negedge clk);
    wr(7, LB);
    rd(7, v);
    check("R5 low level re-sets", v, LB);
    move_pin(1);
    wr(7, LB);
    rd(7, v);
    check("R5 low level inactive clears", v, 0);

    // R10 event and clear in the same cycle
    set_mode(0, 0, 0);
    settle_clear();
    @(negedge clk);
    pad_i[L] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 3'd7; bus_wdata = LB; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(7, v);
    check("R10 set wins over clear", v, LB);

    finish_run();
  end

endmodule